// File: doc/BRIEF.md
# Self-Scrubbing Running-Sum Averager

This block averages the most recent N signed samples. It keeps one running total and an N-stage sample history. On each accepted sample it adds the new value to the total and removes the value that drops out of the history. Because the total is carried from one sample to the next, a corrupted bit in the total or in the history would otherwise bias the output for good.

The block guards against that by watching for quiet input. A sample is quiet when its magnitude is below a small noise limit. When N+1 quiet samples arrive in a row, the history and the total can only hold noise. Both are then wiped to zero and a one-cycle marker is raised. Any upset in stored state therefore lasts only until the next quiet stretch.

Cycles without the valid strobe leave all state unchanged. The output is the total divided by N, rounded toward minus infinity.

Top module: `mavg_scrub_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `avg_out` is 0 and `scrub_pulse` is 0.
- R2: On the clock edge that accepts a valid sample, `avg_out` becomes floor(S/DEPTH). S is the sum of the last DEPTH accepted samples; samples wiped by a scrub count as zero.
- R3: When `in_valid` is low, `avg_out` holds and the stored history and quiet-run count do not change.
- R4: A sample is quiet when its two's-complement magnitude is strictly less than QUIET_LIMIT (3 by default). This applies to negative values as well, so -2 is quiet and -3 and 3 are not.
- R5: The valid sample that completes DEPTH+1 consecutive quiet samples clears both the history and the total. On the next cycle `avg_out` is 0, and later outputs treat the cleared history as zeros.
- R6: Any valid sample that is not quiet restarts the quiet-run count. After it, a further DEPTH+1 quiet samples are needed before a scrub.
- R7: `scrub_pulse` is high for exactly one cycle per scrub. The quiet-run count saturates at DEPTH+1, so a long quiet stretch produces only one scrub.
- R8: The total is DATA_W+log2(DEPTH) bits wide. A history full of +127 gives 127, and a history full of -128 gives -128, with no wrap.
- R9: The most negative input (-128) has magnitude 128 and is treated as active data, not as quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; a sample is accepted on an edge where this is high |
| in_sample | input | DATA_W | Signed input sample |
| avg_out | output | DATA_W | Signed average of the last DEPTH samples |
| scrub_pulse | output | 1 | One-cycle marker raised when a quiet run wipes the state |

## Verification
The bench first drives a rising ramp and a long pseudo-random stream of active samples with gaps in the strobe. These show that the window sum slides correctly and that idle cycles freeze the state. Full-scale runs at +127 and -128 separate a correctly sized total from one that wraps, and the -128 run separates a magnitude test that treats -128 as large from one that treats it as quiet. Quiet runs of +2 and -2 show that the scrub fires on exactly the sample that completes DEPTH+1 quiet samples and not one sample early, and that negative noise counts as quiet. A run interrupted by a sample of exactly the limit, followed by a long saturated quiet stretch, shows that the count restarts and that no second pulse follows.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_DEPTH       = 16;
    localparam int          DEF_QUIET_LIMIT = 3;

    // Status of the quiet-run monitor for the sample currently on the input.
    typedef struct packed {
        logic quiet;   // sample magnitude below the noise limit
        logic fire;    // this sample completes the quiet run: wipe state
    } run_flags_t;

    function automatic int magnitude(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic below_limit(input int v, input int limit);
        return magnitude(v) < limit;
    endfunction

endpackage

// File: rtl/mavg_window.sv
module mavg_window #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                clear,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] oldest
);

    logic signed [W-1:0] tap [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic signed [W-1:0] feed;
        if (g == 0) begin : g_head
            assign feed = din;
        end else begin : g_body
            assign feed = tap[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                tap[g] <= '0;
            end else if (shift_en) begin
                tap[g] <= feed;
            end
        end
    end

    assign oldest = tap[DEPTH-1];

    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (oldest == '0));  // R5

    AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clear) |=> $stable(oldest));  // R3

endmodule

// File: rtl/mavg_quiet_run.sv
module mavg_quiet_run
    import mavg_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    parameter int          LIMIT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic signed [W-1:0] smp,
    output run_flags_t          flags,
    output logic                scrub_q
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 2);
    localparam logic [CNT_W-1:0] RUN_TARGET  = CNT_W'(DEPTH + 1);
    localparam logic [CNT_W-1:0] RUN_PENULT  = CNT_W'(DEPTH);

    logic [CNT_W-1:0] run_cnt;
    logic             quiet;

    assign quiet = below_limit(int'(smp), LIMIT);

    always_comb begin
        flags.quiet = quiet;
        flags.fire  = smp_valid && quiet && (run_cnt == RUN_PENULT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            scrub_q <= 1'b0;
        end else begin
            scrub_q <= flags.fire;
            if (smp_valid) begin
                if (!quiet) begin
                    run_cnt <= '0;
                end else if (run_cnt != RUN_TARGET) begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        scrub_q |=> !scrub_q);  // R7

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_TARGET);  // R7

    AST_ACTIVE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !flags.quiet) |=> (run_cnt == '0));  // R6

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(run_cnt));  // R3

endmodule

// File: rtl/mavg_sum.sv
module mavg_sum #(
    parameter int unsigned W     = 8,
    parameter int unsigned ACC_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    clear,
    input  logic signed [W-1:0]     din,
    input  logic signed [W-1:0]     leaving,
    output logic signed [ACC_W-1:0] acc
);

    logic signed [ACC_W-1:0] acc_next;

    always_comb begin
        acc_next = acc + ACC_W'(din) - ACC_W'(leaving);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc_next;
        end
    end

    AST_TOTAL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!en && !clear) |=> $stable(acc));  // R3

    AST_TOTAL_WIPED: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));  // R5

endmodule

// File: rtl/mavg_scrub_filter.sv
module mavg_scrub_filter
    import mavg_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned DEPTH       = DEF_DEPTH,
    parameter int          QUIET_LIMIT = DEF_QUIET_LIMIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic signed [DATA_W-1:0] avg_out,
    output logic                     scrub_pulse
);

    localparam int unsigned LOG2N = $clog2(DEPTH);
    localparam int unsigned ACC_W = DATA_W + LOG2N;

    run_flags_t              flags;
    logic signed [DATA_W-1:0] leaving;
    logic signed [ACC_W-1:0]  total;
    logic                     shift_en;

    assign shift_en = in_valid && !flags.fire;

    mavg_quiet_run #(
        .W     (DATA_W),
        .DEPTH (DEPTH),
        .LIMIT (QUIET_LIMIT)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (in_valid),
        .smp       (in_sample),
        .flags     (flags),
        .scrub_q   (scrub_pulse)
    );

    mavg_window #(
        .W     (DATA_W),
        .DEPTH (DEPTH)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .clear    (flags.fire),
        .din      (in_sample),
        .oldest   (leaving)
    );

    mavg_sum #(
        .W     (DATA_W),
        .ACC_W (ACC_W)
    ) u_sum (
        .clk     (clk),
        .rst     (rst),
        .en      (shift_en),
        .clear   (flags.fire),
        .din     (in_sample),
        .leaving (leaving),
        .acc     (total)
    );

    // Dividing by a power-of-two depth: the upper slice is an arithmetic shift.
    assign avg_out = total[ACC_W-1:LOG2N];

    AST_SCRUB_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        scrub_pulse |-> (avg_out == '0));  // R5

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(avg_out));  // R3

endmodule

// File: tb/mavg_scrub_filter_tb.sv
module mavg_scrub_filter_tb;

    localparam int N   = 16;
    localparam int W   = 8;
    localparam int LIM = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic signed [W-1:0] avg_out;
    logic                scrub_pulse;

    int total_checks = 0;
    int bad_checks   = 0;
    bit finished     = 0;

    int    q_avg [$];
    bit    q_scr [$];
    string q_tag [$];

    int hist [N];
    int run_cnt = 0;

    always #5 clk = ~clk;

    mavg_scrub_filter #(.DATA_W(W), .DEPTH(N), .QUIET_LIMIT(LIM)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .avg_out     (avg_out),
        .scrub_pulse (scrub_pulse)
    );

    function automatic int floor_div(input int s);
        int r;
        r = s % N;
        if (r < 0) r += N;
        return (s - r) / N;
    endfunction

    task automatic check_val(input string tag, input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report_and_end();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic drive(input bit v, input int x, input string tag);
        int  prev;
        int  sum;
        bit  quiet;
        bit  fire;
        string t;
        @(negedge clk);
        in_valid  = v;
        in_sample = W'(x);
        fire = 0;
        if (v) begin
            quiet = ((x < 0) ? -x : x) < LIM;
            prev  = run_cnt;
            if (!quiet) run_cnt = 0;
            else if (run_cnt < N + 1) run_cnt++;
            fire = quiet && (prev == N);
            if (fire) begin
                for (int i = 0; i < N; i++) hist[i] = 0;
            end else begin
                for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = x;
            end
        end
        sum = 0;
        for (int i = 0; i < N; i++) sum += hist[i];
        if (!v) t = "R3";
        else if (fire && tag == "R2") t = "R5";
        else t = tag;
        q_avg.push_back(floor_div(sum));
        q_scr.push_back(fire);
        q_tag.push_back(t);
    endtask

    // Monitor: compare each registered result shortly after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_avg.size() > 0) begin
                int    e_avg;
                bit    e_scr;
                string tg;
                e_avg = q_avg.pop_front();
                e_scr = q_scr.pop_front();
                tg    = q_tag.pop_front();
                check_val(tg, int'(avg_out), e_avg);
                check_val((e_scr || scrub_pulse) ? "R7" : tg, int'(scrub_pulse), int'(e_scr));
            end
        end
    end

    initial begin
        #(200000 * 10);
        total_checks++;
        bad_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report_and_end();
    end

    initial begin
        for (int i = 0; i < N; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check_val("R1", int'(avg_out), 0);
        check_val("R1", int'(scrub_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        check_val("R1", int'(avg_out), 0);
        check_val("R1", int'(scrub_pulse), 0);

        // R2: rising ramp of active samples
        for (int i = 0; i < 20; i++) drive(1, 10 + 2 * i, "R2");
        // R3: strobe low, input wiggles, state must hold
        for (int i = 0; i < 5; i++) drive(0, 90 - 30 * i, "R3");
        // R9 / R8: most negative sample is active; full window gives -128
        for (int i = 0; i < 20; i++) drive(1, -128, "R9");
        // R8: full positive window gives 127
        for (int i = 0; i < 18; i++) drive(1, 127, "R8");
        // R5: DEPTH+1 quiet samples wipe state on the last one
        for (int i = 0; i < N + 1; i++) drive(1, 2, "R5");
        // R7: saturated run, no further pulse
        for (int i = 0; i < 12; i++) drive(1, 1, "R7");
        // R6: a sample equal to the limit restarts the run
        drive(1, 50, "R6");
        for (int i = 0; i < N; i++) drive(1, -1, "R6");
        drive(1, 3, "R6");
        for (int i = 0; i < N; i++) drive(1, 2, "R6");
        drive(1, 0, "R5");
        // R4: negative noise counts as quiet
        for (int i = 0; i < 5; i++) drive(1, 60, "R4");
        drive(1, -3, "R4");
        for (int i = 0; i < N + 1; i++) drive(1, -2, "R4");
        drive(1, 40, "R2");
        // R2: pseudo-random stream with gaps
        for (int i = 0; i < 400; i++) begin
            bit v;
            int x;
            v = ($urandom_range(0, 9) < 8);
            x = int'($urandom_range(0, 255)) - 128;
            if (i % 100 > 70) x = int'($urandom_range(0, 4)) - 2;
            drive(v, x, "R2");
        end
        drive(0, 0, "R3");
        repeat (3) @(negedge clk);
        report_and_end();
    end

endmodule